// File: doc/BRIEF.md
# Credit-Gated Read Request Arbiter

This block merges read requests from a set of clients (ten by default) onto a single outgoing read-request channel. Each client offers requests through its own valid/ready port carrying an address, a byte length and a per-atom enable mask. The block keeps one held request per client. It forwards a held request only when that client's response buffer is certain to have room for every atom the request will bring back.

Room is tracked by one credit counter per client. The counter starts at the depth of that client's response buffer, measured in atoms. When a request is issued, the counter loses one credit for each enabled atom of the request. Disabled atoms are not charged, because they return nothing. The counter gains one credit for each return pulse the client sends as it drains its response buffer. Eligible clients share the output channel through a round-robin choice. The output is registered and stays stable while it waits for the consumer.

Top module: `credit_rd_arb`

## Requirements
- R1: After reset, `rq_valid` is 0, every `cl_req_ready` bit is 1, both error vectors are all zero, and every credit counter holds `RSP_DEPTH`.
- R2: Each client holds at most one request. `cl_req_ready[i]` is 1 exactly when client i holds nothing. A request is taken on a clock edge where valid and ready are both 1, and it is held until it is issued.
- R3: The charge of a request counts the set bits of `atom_en` among atoms 0 to n-1, where n is `len` divided by `ATOM_BYTES` (rounded down), and bit k of `atom_en` belongs to atom k. Set bits at position n or above are not charged.
- R4: A held request is issued only when its client's credit is at least its charge. Otherwise it waits, and it becomes issuable on the cycle after enough credits have returned.
- R5: When a request is issued, its charge is subtracted from the client's credit. Each `cl_credit_ret[i]` pulse adds one credit. Both can happen in the same cycle.
- R6: The output carries at most one request per cycle. While `rq_valid` is 1 and `rq_ready` is 0, `rq_valid`, `rq_addr`, `rq_len`, `rq_atom_en` and `rq_client` hold their values.
- R7: Among eligible clients, the winner is the first one found in index order that starts one past the last granted client and wraps around. After reset, the search starts at client 0. `rq_client` gives the winner's index.
- R8: A credit return that would take a counter above `RSP_DEPTH` leaves the counter at `RSP_DEPTH`. It also sets `err_credit_ovf[i]`, which stays at 1 until reset.
- R9: A held request whose charge exceeds `RSP_DEPTH` drives `err_oversize[i]` to 1 while it is held. Such a request is never issued, and the other clients continue to be served.
- R10: A request taken at clock edge k, from an eligible client, appears on the output after edge k+1, provided that the output register is empty or is handing over at k+1 and no other client wins that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cl_req_valid | input | NUM_CLIENTS | Per-client request valid |
| cl_req_ready | output | NUM_CLIENTS | Per-client request ready; 1 when the client's held slot is empty |
| cl_req_addr | input | NUM_CLIENTS*ADDR_W | Per-client address; client i uses slice i |
| cl_req_len | input | NUM_CLIENTS*LEN_W | Per-client length in bytes |
| cl_req_atom_en | input | NUM_CLIENTS*MAX_ATOMS | Per-client atom enables; bit k belongs to atom k |
| cl_credit_ret | input | NUM_CLIENTS | One-cycle pulse that returns one atom credit |
| rq_valid | output | 1 | Output request valid |
| rq_ready | input | 1 | Output request accepted by the consumer |
| rq_addr | output | ADDR_W | Address of the issued request |
| rq_len | output | LEN_W | Length of the issued request |
| rq_atom_en | output | MAX_ATOMS | Atom enables of the issued request |
| rq_client | output | CID_W | Index of the client that issued the request |
| err_credit_ovf | output | NUM_CLIENTS | Sticky flag: a credit return would have exceeded the depth |
| err_oversize | output | NUM_CLIENTS | The held request charges more than the depth and cannot issue |

## Verification
The bench drives the inputs a few nanoseconds after each rising edge and samples on the falling edge. A request taken at edge k is therefore expected to be absent at the falling edge after k and present, from the right client, at the falling edge after k+1. A credit return pulsed at edge k allows a waiting request to issue at edge k+1. The scoreboard pops an expected entry only on a falling edge where valid and ready are both 1, so each transfer is compared in the cycle it completes. Blocked cases are checked by waiting several cycles and confirming that nothing was issued. Each blocked request is then released with a single credit, which shows that the credit count held its exact value.

// File: rtl/crq_pkg.sv
package crq_pkg;

    parameter int ADDR_W     = 32;
    parameter int MAX_ATOMS  = 8;
    parameter int ATOM_BYTES = 32;

    localparam int ATOM_SHIFT = $clog2(ATOM_BYTES);
    localparam int LEN_W      = $clog2(MAX_ATOMS * ATOM_BYTES) + 1;
    localparam int CHG_W      = $clog2(MAX_ATOMS + 1);

    typedef struct packed {
        logic [ADDR_W-1:0]    addr;
        logic [LEN_W-1:0]     len;
        logic [MAX_ATOMS-1:0] atom_en;
    } rd_req_t;

    // Credits charged: enabled atoms that lie inside the request length.
    function automatic logic [CHG_W-1:0] charge_of(input rd_req_t r);
        logic [LEN_W-1:0] n_atoms;
        logic [CHG_W-1:0] c;
        n_atoms = r.len >> ATOM_SHIFT;
        c = '0;
        for (int k = 0; k < MAX_ATOMS; k++) begin
            if ((LEN_W'(k) < n_atoms) && r.atom_en[k]) begin
                c = c + 1'b1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/crq_client_slot.sv
module crq_client_slot
    import crq_pkg::*;
#(
    parameter int RSP_DEPTH = 4,
    localparam int CREDIT_W = $clog2(RSP_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  rd_req_t             in_req,
    input  logic                credit_ret,
    input  logic                grant,
    output logic                eligible,
    output rd_req_t             held_req,
    output logic [CREDIT_W-1:0] credit,
    output logic                ovf_err,
    output logic                oversize_err
);

    localparam int CMP_W = ((CHG_W > CREDIT_W) ? CHG_W : CREDIT_W) + 2;

    logic                full_q;
    rd_req_t             req_q;
    logic [CREDIT_W-1:0] credit_q;
    logic                ovf_q;
    logic [CHG_W-1:0]    charge;
    logic                too_big;
    logic [CMP_W-1:0]    credit_next;
    logic                ovf_hit;

    assign charge   = charge_of(req_q);
    assign too_big  = CMP_W'(charge) > CMP_W'(RSP_DEPTH);
    assign eligible = full_q && !too_big && (CMP_W'(charge) <= CMP_W'(credit_q));
    assign in_ready = !full_q;

    always_comb begin
        credit_next = CMP_W'(credit_q)
                    - (grant ? CMP_W'(charge) : CMP_W'(0))
                    + (credit_ret ? CMP_W'(1) : CMP_W'(0));
        ovf_hit = credit_next > CMP_W'(RSP_DEPTH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q   <= 1'b0;
            req_q    <= '0;
            credit_q <= CREDIT_W'(RSP_DEPTH);
            ovf_q    <= 1'b0;
        end else begin
            if (grant) begin
                full_q <= 1'b0;
            end else if (in_valid && !full_q) begin
                full_q <= 1'b1;
                req_q  <= in_req;
            end
            credit_q <= ovf_hit ? CREDIT_W'(RSP_DEPTH) : credit_next[CREDIT_W-1:0];
            if (ovf_hit) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign held_req     = req_q;
    assign credit       = credit_q;
    assign ovf_err      = ovf_q;
    assign oversize_err = full_q && too_big;

endmodule

// File: rtl/crq_rr_pick.sv
module crq_rr_pick #(
    parameter int NUM_CLIENTS = 10,
    localparam int CID_W = $clog2(NUM_CLIENTS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CLIENTS-1:0] elig,
    input  logic                   advance,
    output logic [NUM_CLIENTS-1:0] pick,
    output logic [CID_W-1:0]       pick_idx,
    output logic                   any
);

    logic [CID_W-1:0] last_q;

    always_comb begin
        int idx;
        pick     = '0;
        pick_idx = '0;
        any      = 1'b0;
        for (int off = 1; off <= NUM_CLIENTS; off++) begin
            idx = (int'(last_q) + off) % NUM_CLIENTS;
            if (!any && elig[idx]) begin
                any       = 1'b1;
                pick[idx] = 1'b1;
                pick_idx  = CID_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= CID_W'(NUM_CLIENTS - 1);
        end else if (advance && any) begin
            last_q <= pick_idx;
        end
    end

endmodule

// File: rtl/credit_rd_arb.sv
module credit_rd_arb
    import crq_pkg::*;
#(
    parameter int NUM_CLIENTS = 10,
    parameter int RSP_DEPTH   = 4,
    localparam int CID_W      = $clog2(NUM_CLIENTS),
    localparam int CREDIT_W   = $clog2(RSP_DEPTH + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_CLIENTS-1:0]           cl_req_valid,
    output logic [NUM_CLIENTS-1:0]           cl_req_ready,
    input  logic [NUM_CLIENTS*ADDR_W-1:0]    cl_req_addr,
    input  logic [NUM_CLIENTS*LEN_W-1:0]     cl_req_len,
    input  logic [NUM_CLIENTS*MAX_ATOMS-1:0] cl_req_atom_en,
    input  logic [NUM_CLIENTS-1:0]           cl_credit_ret,
    output logic                             rq_valid,
    input  logic                             rq_ready,
    output logic [ADDR_W-1:0]                rq_addr,
    output logic [LEN_W-1:0]                 rq_len,
    output logic [MAX_ATOMS-1:0]             rq_atom_en,
    output logic [CID_W-1:0]                 rq_client,
    output logic [NUM_CLIENTS-1:0]           err_credit_ovf,
    output logic [NUM_CLIENTS-1:0]           err_oversize
);

    rd_req_t                       held [NUM_CLIENTS];
    logic [NUM_CLIENTS-1:0]        elig;
    logic [NUM_CLIENTS-1:0]        pick;
    logic [NUM_CLIENTS-1:0]        grant;
    logic [CID_W-1:0]              pick_idx;
    logic                          any;
    logic                          issue;
    logic [NUM_CLIENTS*CREDIT_W-1:0] credit_flat;

    rd_req_t          out_q;
    logic             out_valid_q;
    logic [CID_W-1:0] out_cid_q;

    for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_slot
        rd_req_t in_req;
        assign in_req.addr    = cl_req_addr[i*ADDR_W +: ADDR_W];
        assign in_req.len     = cl_req_len[i*LEN_W +: LEN_W];
        assign in_req.atom_en = cl_req_atom_en[i*MAX_ATOMS +: MAX_ATOMS];

        crq_client_slot #(.RSP_DEPTH(RSP_DEPTH)) slot_i (
            .clk          (clk),
            .rst          (rst),
            .in_valid     (cl_req_valid[i]),
            .in_ready     (cl_req_ready[i]),
            .in_req       (in_req),
            .credit_ret   (cl_credit_ret[i]),
            .grant        (grant[i]),
            .eligible     (elig[i]),
            .held_req     (held[i]),
            .credit       (credit_flat[i*CREDIT_W +: CREDIT_W]),
            .ovf_err      (err_credit_ovf[i]),
            .oversize_err (err_oversize[i])
        );
    end

    crq_rr_pick #(.NUM_CLIENTS(NUM_CLIENTS)) pick_i (
        .clk      (clk),
        .rst      (rst),
        .elig     (elig),
        .advance  (issue),
        .pick     (pick),
        .pick_idx (pick_idx),
        .any      (any)
    );

    assign issue = any && (!out_valid_q || rq_ready);
    assign grant = pick & {NUM_CLIENTS{issue}};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_q       <= '0;
            out_cid_q   <= '0;
        end else if (issue) begin
            out_valid_q <= 1'b1;
            out_q       <= held[pick_idx];
            out_cid_q   <= pick_idx;
        end else if (rq_ready) begin
            out_valid_q <= 1'b0;
        end
    end

    assign rq_valid   = out_valid_q;
    assign rq_addr    = out_q.addr;
    assign rq_len     = out_q.len;
    assign rq_atom_en = out_q.atom_en;
    assign rq_client  = out_cid_q;

endmodule

// File: rtl/crq_checker.sv
module crq_checker
    import crq_pkg::*;
#(
    parameter int NUM_CLIENTS = 10,
    parameter int RSP_DEPTH   = 4,
    localparam int CID_W      = $clog2(NUM_CLIENTS),
    localparam int CREDIT_W   = $clog2(RSP_DEPTH + 1)
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            rq_valid,
    input logic                            rq_ready,
    input logic [ADDR_W-1:0]               rq_addr,
    input logic [CID_W-1:0]                rq_client,
    input logic [NUM_CLIENTS-1:0]          grant,
    input logic [NUM_CLIENTS-1:0]          elig,
    input logic [NUM_CLIENTS-1:0]          err_oversize,
    input logic [NUM_CLIENTS-1:0]          err_credit_ovf,
    input logic [NUM_CLIENTS*CREDIT_W-1:0] credit_flat
);

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_addr) && $stable(rq_client)));

    p_one_grant_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_grant_eligible_r4: assert property (@(posedge clk) disable iff (rst)
        (grant & ~elig) == '0);

    p_no_oversize_issue_r9: assert property (@(posedge clk) disable iff (rst)
        (grant & err_oversize) == '0);

    p_issue_visible_r10: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |=> rq_valid);

    for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_chk
        p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
            err_credit_ovf[i] |=> err_credit_ovf[i]);

        always @(posedge clk) begin
            if (!rst) begin
                p_credit_bound_r5: assert (credit_flat[i*CREDIT_W +: CREDIT_W] <= CREDIT_W'(RSP_DEPTH));
            end
        end
    end

endmodule

bind credit_rd_arb crq_checker #(
    .NUM_CLIENTS (NUM_CLIENTS),
    .RSP_DEPTH   (RSP_DEPTH)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .rq_valid       (rq_valid),
    .rq_ready       (rq_ready),
    .rq_addr        (rq_addr),
    .rq_client      (rq_client),
    .grant          (grant),
    .elig           (elig),
    .err_oversize   (err_oversize),
    .err_credit_ovf (err_credit_ovf),
    .credit_flat    (credit_flat)
);

// File: tb/credit_rd_arb_tb_top.sv
`timescale 1ns/1ps
module credit_rd_arb_tb_top;
    import crq_pkg::*;

    localparam int N     = 10;
    localparam int DEPTH = 4;
    localparam int CID_W = $clog2(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [N-1:0]           cl_req_valid = '0;
    logic [N-1:0]           cl_req_ready;
    logic [N*ADDR_W-1:0]    cl_req_addr = '0;
    logic [N*LEN_W-1:0]     cl_req_len = '0;
    logic [N*MAX_ATOMS-1:0] cl_req_atom_en = '0;
    logic [N-1:0]           cl_credit_ret = '0;
    logic                   rq_valid;
    logic                   rq_ready = 1'b1;
    logic [ADDR_W-1:0]      rq_addr;
    logic [LEN_W-1:0]       rq_len;
    logic [MAX_ATOMS-1:0]   rq_atom_en;
    logic [CID_W-1:0]       rq_client;
    logic [N-1:0]           err_credit_ovf;
    logic [N-1:0]           err_oversize;

    credit_rd_arb #(.NUM_CLIENTS(N), .RSP_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst),
        .cl_req_valid(cl_req_valid), .cl_req_ready(cl_req_ready),
        .cl_req_addr(cl_req_addr), .cl_req_len(cl_req_len),
        .cl_req_atom_en(cl_req_atom_en), .cl_credit_ret(cl_credit_ret),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
        .rq_len(rq_len), .rq_atom_en(rq_atom_en), .rq_client(rq_client),
        .err_credit_ovf(err_credit_ovf), .err_oversize(err_oversize)
    );

    typedef struct {
        int          cid;
        logic [31:0] addr;
        int          len;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    task automatic chk(input string tag, input bit ok, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Drivers: every task starts and ends 5 ns after a rising edge.
    task automatic stage(input int c, input logic [31:0] a, input int atoms,
                         input logic [7:0] en, input string tag);
        exp_t e;
        cl_req_valid[c] = 1'b1;
        cl_req_addr[c*ADDR_W +: ADDR_W]          = a;
        cl_req_len[c*LEN_W +: LEN_W]             = LEN_W'(atoms * ATOM_BYTES);
        cl_req_atom_en[c*MAX_ATOMS +: MAX_ATOMS] = en;
        e.cid = c; e.addr = a; e.len = atoms * ATOM_BYTES; e.tag = tag;
        if (tag != "") exp_q.push_back(e);
    endtask

    task automatic commit();
        @(posedge clk); #5;
        cl_req_valid = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #5; end
    endtask

    task automatic ret(input int c);
        cl_credit_ret[c] = 1'b1;
        @(posedge clk); #5;
        cl_credit_ret[c] = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 60 && exp_q.size() != 0; i++) begin
            @(posedge clk); #5;
        end
        chk({tag, " pending expected requests"}, exp_q.size() == 0, exp_q.size(), 0);
    endtask

    // Monitor: a transfer completes at the next rising edge when valid and ready
    always @(negedge clk) begin
        if (!rst && rq_valid && rq_ready) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected issue client", 1'b0, rq_client, N);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " client"}, int'(rq_client) == e.cid, rq_client, e.cid);
                chk({e.tag, " addr"}, rq_addr == e.addr, rq_addr, e.addr);
                chk({e.tag, " len"}, int'(rq_len) == e.len, rq_len, e.len);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        chk("R1 rq_valid", rq_valid == 1'b0, rq_valid, 0);
        chk("R1 ready", cl_req_ready == '1, cl_req_ready, {N{1'b1}});
        chk("R1 err_credit_ovf", err_credit_ovf == '0, err_credit_ovf, 0);
        chk("R1 err_oversize", err_oversize == '0, err_oversize, 0);
        rst = 1'b0;
        idle(1);

        // R10 latency and R2 acceptance
        chk("R2 ready before push", cl_req_ready[3] == 1'b1, cl_req_ready[3], 1);
        stage(3, 32'h1000, 4, 8'h0F, "R10 basic");
        commit();
        @(negedge clk);
        chk("R10 not yet valid", rq_valid == 1'b0, rq_valid, 0);
        @(negedge clk);
        chk("R10 valid one edge later", rq_valid == 1'b1, rq_valid, 1);
        chk("R10 client", rq_client == 3, rq_client, 3);
        @(posedge clk); #5;
        drain("R10");

        // R4/R5: client 3 has 0 credits now
        stage(3, 32'h2000, 1, 8'h01, "");
        commit();
        idle(5);
        chk("R4 blocked without credit", rq_valid == 1'b0, rq_valid, 0);
        chk("R2 slot holds, ready low", cl_req_ready[3] == 1'b0, cl_req_ready[3], 0);
        stage(3, 32'h2000, 1, 8'h01, "R4 released by credit");
        cl_req_valid[3] = 1'b0;
        ret(3);
        drain("R4");
        chk("R2 ready after issue", cl_req_ready[3] == 1'b1, cl_req_ready[3], 1);
        repeat (4) ret(3);
        chk("R8 no error on legal returns", err_credit_ovf == '0, err_credit_ovf, 0);

        // R3: only enabled atoms within length are charged
        stage(5, 32'h3000, 4, 8'hF5, "R3 charge two");
        commit();
        drain("R3 first");
        stage(5, 32'h3100, 2, 8'h03, "R3 remaining two credits");
        commit();
        drain("R3 second");
        stage(5, 32'h3200, 1, 8'h01, "");
        commit();
        idle(5);
        chk("R5 credits exhausted", rq_valid == 1'b0, rq_valid, 0);
        stage(5, 32'h3200, 1, 8'h01, "R5 one credit releases");
        cl_req_valid[5] = 1'b0;
        ret(5);
        drain("R5");
        repeat (4) ret(5);

        // R7/R6: round robin after last grant (client 5), output held
        rq_ready = 1'b0;
        stage(7, 32'h7000, 1, 8'h01, "R7 first after 5");
        stage(1, 32'h1100, 1, 8'h01, "R7 wrap to 1");
        stage(2, 32'h2200, 1, 8'h01, "R7 then 2");
        commit();
        idle(1);
        chk("R7 winner is 7", rq_valid && rq_client == 7, rq_client, 7);
        idle(3);
        chk("R6 client held", rq_valid && rq_client == 7, rq_client, 7);
        chk("R6 addr held", rq_addr == 32'h7000, rq_addr, 32'h7000);
        rq_ready = 1'b1;
        drain("R7 order");

        stage(0, 32'h0A00, 1, 8'h01, "");
        stage(9, 32'h9900, 1, 8'h01, "R7 9 before 0");
        stage(0, 32'h0A00, 1, 8'h01, "R7 0 after 9");
        commit();
        drain("R7 second round");

        // R9: oversize charge never issues, others still served
        stage(4, 32'h4000, 8, 8'h1F, "");
        commit();
        idle(3);
        chk("R9 oversize flag", err_oversize == (N'(1) << 4), err_oversize, N'(1) << 4);
        chk("R9 not issued", rq_valid == 1'b0, rq_valid, 0);
        chk("R9 slot stays held", cl_req_ready[4] == 1'b0, cl_req_ready[4], 0);
        stage(6, 32'h6000, 1, 8'h01, "R9 other client served");
        commit();
        drain("R9");
        chk("R9 flag persists", err_oversize[4] == 1'b1, err_oversize[4], 1);

        // R8: return at full credit
        ret(8);
        chk("R8 overflow flag", err_credit_ovf == (N'(1) << 8), err_credit_ovf, N'(1) << 8);
        stage(8, 32'h8000, 4, 8'h0F, "R8 full charge");
        commit();
        drain("R8");
        stage(8, 32'h8100, 1, 8'h01, "");
        commit();
        idle(5);
        chk("R8 counter saturated at depth", rq_valid == 1'b0, rq_valid, 0);
        chk("R8 flag sticky", err_credit_ovf[8] == 1'b1, err_credit_ovf[8], 1);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule